// File: doc/BRIEF.md
# UTOPIA Level 1 Transmit-Side Cell Receiver (PHY side)

This block sits on the physical-layer side of an 8-bit, point-to-point UTOPIA Level 1 link and receives cells that the link layer sends in the ingress direction. It reports cell-space availability to the link layer by passing the user-side space flag straight through. The link layer sends one octet per clock while it holds its active-low enable. The block finds the start of each cell, counts octets, and forwards every cell as a framed byte stream on the user side, with first-byte and last-byte markers.

A mode input selects the cell length on the bus: 54 octets or 53 octets. With 53-octet cells the block inserts a filler byte of value 0x00 after the fifth octet (the header check byte). The user side therefore always sees 54 bytes: four header bytes, the check byte, the filler byte and 48 payload bytes. The insertion adds one byte of backlog to a small output queue. That backlog drains in any clock cycle in which no octet is captured. In 53-octet mode the link layer leaves at least one such cycle between cells. A start-of-cell marker that arrives inside an unfinished cell abandons that cell, raises a one-cycle error pulse, and starts a new count. Everything runs on the single transmit clock.

Top module: `cell_ingress_rx`

## Requirements
- R1: `txClav` equals `wAvail` in every cycle, with no register in between.
- R2: An octet is taken from `txData` only in cycles where `txEnN` is 0. When `txEnN` is 1 in the middle of a cell, the octet position is held and the cell resumes at the next octet once `txEnN` returns to 0.
- R3: A cell starts in a cycle where `txEnN` is 0 and `txSoc` is 1, including the first cycle in which `txEnN` falls. That octet becomes the first user byte, marked with `outSop` = 1.
- R4: When `cellSizeSel` is 1 at start-of-cell, 54 octets are taken and forwarded unchanged and in order. `outEop` = 1 on the 54th byte only.
- R5: When `cellSizeSel` is 0 at start-of-cell, 53 octets are taken. The user stream carries octets 1 to 5, then 0x00, then octets 6 to 53, which makes 54 bytes. `outEop` = 1 on the 54th byte only.
- R6: A captured octet appears on `outData` with `outValid` = 1 in the cycle after the clock edge that captured it, provided the output queue is empty.
- R7: Octets with `txEnN` = 0 that arrive while no cell is open (before any start-of-cell, or after a cell completes) produce no user byte.
- R8: If `txSoc` = 1 and `txEnN` = 0 while a cell is still incomplete, `cellErr` pulses for exactly one cycle. Counting restarts at the new octet, which is forwarded with `outSop` = 1, and the new cell has its full length.
- R9: After the last octet of a cell the block returns to idle. Further octets are ignored until the next start-of-cell.
- R10: While `rstN` is 0 and just after reset, `outValid` and `cellErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit interface clock |
| rstN | input | 1 | Active-low synchronous reset |
| cellSizeSel | input | 1 | 1: 54-octet cells on the bus; 0: 53-octet cells with filler insertion |
| wAvail | input | 1 | User side has room for another cell |
| txClav | output | 1 | Cell-space available toward the link layer |
| txEnN | input | 1 | Active-low transfer enable from the link layer |
| txSoc | input | 1 | Start-of-cell marker, high on the first octet |
| txData | input | 8 | Octet from the link layer |
| outValid | output | 1 | User byte valid |
| outData | output | 8 | User byte |
| outSop | output | 1 | First byte of a cell |
| outEop | output | 1 | Last (54th) byte of a cell |
| cellErr | output | 1 | One-cycle pulse when a cell is abandoned by a new start-of-cell |

## Verification
Several properties are checked on every cycle by the assertions:
- A held enable never makes an empty queue produce a byte.
- A start-of-cell on an empty queue is followed next cycle by a byte marked as first.
- The error pulse is only raised for a start-of-cell that interrupts an open cell.
- The octet position never passes the cell length, and the block closes the cell after the last octet.
- The output queue never overflows.

The bench scenarios cover what depends on whole streams:
- Byte order and content across both cell sizes and enable gaps at chosen positions.
- The filler placed exactly after the fifth octet.
- Stray octets dropped outside a cell.
- The byte count of an abandoned cell and of the one that replaces it.

// File: rtl/cell_ingress_pkg.sv
package cell_ingress_pkg;

  parameter int unsigned BYTE_W = 8;

  // Control-to-datapath strobes for one clock cycle.
  typedef struct packed {
    logic push;   // forward the octet captured this cycle
    logic fill;   // append a filler byte after it
    logic sop;    // captured octet opens a cell
    logic eop;    // captured octet closes a cell
  } strobe_t;

  // One entry of the user-side output queue.
  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              sop;
    logic              eop;
  } qentry_t;

endpackage

// File: rtl/cell_ingress_ctrl.sv
module cell_ingress_ctrl
  import cell_ingress_pkg::*;
#(
  parameter int unsigned LONG_LEN  = 54,
  parameter int unsigned SHORT_LEN = 53,
  parameter int unsigned HEC_IDX   = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    txEnN,
  input  logic    txSoc,
  input  logic    cellSizeSel,
  output strobe_t strb,
  output logic    cellErr
);

  localparam int unsigned IDX_W = $clog2(LONG_LEN);
  localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_LEN - 1);
  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_LEN - 1);
  localparam logic [IDX_W-1:0] HEC_POS    = IDX_W'(HEC_IDX);

  logic             inCell;
  logic             shortMode;
  logic [IDX_W-1:0] idx;

  logic             capture;
  logic             startNow;
  logic             active;
  logic             curShort;
  logic [IDX_W-1:0] curIdx;
  logic [IDX_W-1:0] lastIdx;

  always_comb begin
    capture  = !txEnN;
    startNow = capture && txSoc;
    curShort = startNow ? !cellSizeSel : shortMode;
    curIdx   = startNow ? '0 : idx;
    active   = startNow || (capture && inCell);
    lastIdx  = curShort ? SHORT_LAST : LONG_LAST;

    strb.push = active;
    strb.sop  = startNow;
    strb.eop  = active && (curIdx == lastIdx);
    strb.fill = active && curShort && (curIdx == HEC_POS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inCell    <= 1'b0;
      shortMode <= 1'b0;
      idx       <= '0;
      cellErr   <= 1'b0;
    end else begin
      cellErr <= startNow && inCell;
      if (startNow) shortMode <= !cellSizeSel;
      if (active) begin
        if (strb.eop) begin
          inCell <= 1'b0;
          idx    <= '0;
        end else begin
          inCell <= 1'b1;
          idx    <= curIdx + 1'b1;
        end
      end
    end
  end

  // R4 / R5: the octet position stays below the longest cell length
  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    idx <= LONG_LAST);

  // R8: an error pulse only follows a start-of-cell with enable low
  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    cellErr |-> $past(txSoc && !txEnN));

  // R9: the cell is closed after its last octet
  assert_idle_after_eop_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.eop |=> !inCell);

endmodule

// File: rtl/cell_ingress_dp.sv
module cell_ingress_dp
  import cell_ingress_pkg::*;
#(
  parameter int unsigned Q_DEPTH  = 4,
  parameter logic [BYTE_W-1:0] FILL_VAL = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [BYTE_W-1:0] inData,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  output logic              outSop,
  output logic              outEop
);

  localparam int unsigned CNT_W = $clog2(Q_DEPTH + 1);

  qentry_t    q     [Q_DEPTH];
  qentry_t    qNext [Q_DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] basePos;
  logic             pop;
  qentry_t          newEntry;
  qentry_t          fillEntry;

  always_comb begin
    pop       = (cnt != '0);
    basePos   = cnt - CNT_W'(pop);
    newEntry  = '{data: inData, sop: strb.sop, eop: strb.eop};
    fillEntry = '{data: FILL_VAL, sop: 1'b0, eop: 1'b0};
    for (int i = 0; i < Q_DEPTH; i++) begin
      if (pop) qNext[i] = (i == Q_DEPTH - 1) ? '0 : q[(i + 1) % Q_DEPTH];
      else     qNext[i] = q[i];
      if (strb.push && (CNT_W'(i) == basePos))          qNext[i] = newEntry;
      if (strb.fill && (CNT_W'(i) == basePos + 1'b1))   qNext[i] = fillEntry;
    end
    cntNext = basePos + CNT_W'(strb.push) + CNT_W'(strb.fill);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      for (int i = 0; i < Q_DEPTH; i++) q[i] <= '0;
    end else begin
      cnt <= cntNext;
      for (int i = 0; i < Q_DEPTH; i++) q[i] <= qNext[i];
    end
  end

  assign outValid = (cnt != '0);
  assign outData  = q[0].data;
  assign outSop   = outValid && q[0].sop;
  assign outEop   = outValid && q[0].eop;

  // R5: filler backlog must fit in the queue
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (32'(basePos) + 32'(strb.push) + 32'(strb.fill)) <= Q_DEPTH);

  // R5: a filler byte is only requested together with a forwarded octet
  assert_fill_with_push_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.fill |-> strb.push);

endmodule

// File: rtl/cell_ingress_rx.sv
module cell_ingress_rx
  import cell_ingress_pkg::*;
#(
  parameter int unsigned LONG_LEN  = 54,
  parameter int unsigned SHORT_LEN = 53,
  parameter int unsigned HEC_IDX   = 4,
  parameter int unsigned Q_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cellSizeSel,
  input  logic              wAvail,
  output logic              txClav,
  input  logic              txEnN,
  input  logic              txSoc,
  input  logic [BYTE_W-1:0] txData,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  output logic              outSop,
  output logic              outEop,
  output logic              cellErr
);

  strobe_t strb;

  assign txClav = wAvail;

  cell_ingress_ctrl #(
    .LONG_LEN (LONG_LEN),
    .SHORT_LEN(SHORT_LEN),
    .HEC_IDX  (HEC_IDX)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txEnN      (txEnN),
    .txSoc      (txSoc),
    .cellSizeSel(cellSizeSel),
    .strb       (strb),
    .cellErr    (cellErr)
  );

  cell_ingress_dp #(
    .Q_DEPTH (Q_DEPTH),
    .FILL_VAL('0)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inData  (txData),
    .outValid(outValid),
    .outData (outData),
    .outSop  (outSop),
    .outEop  (outEop)
  );

  // R2: with enable held high, an empty queue stays empty
  assert_hold_no_byte_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txEnN && !outValid) |=> !outValid);

  // R3: start-of-cell on an empty queue shows a first byte next cycle
  assert_soc_to_sop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!txEnN && txSoc && !outValid) |=> (outValid && outSop));

  // R10: no output activity in the cycle after a reset edge
  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rstN |=> (!outValid && !cellErr));

endmodule

// File: tb/cell_ingress_rx_bench.sv
module cell_ingress_rx_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cellSizeSel = 1'b1;
  logic       wAvail = 1'b0;
  logic       txClav;
  logic       txEnN = 1'b1;
  logic       txSoc = 1'b0;
  logic [7:0] txData = '0;
  logic       outValid;
  logic [7:0] outData;
  logic       outSop;
  logic       outEop;
  logic       cellErr;

  always #10 clk = ~clk;

  cell_ingress_rx u_cell_ingress_rx (
    .clk(clk), .rstN(rstN), .cellSizeSel(cellSizeSel), .wAvail(wAvail),
    .txClav(txClav), .txEnN(txEnN), .txSoc(txSoc), .txData(txData),
    .outValid(outValid), .outData(outData), .outSop(outSop),
    .outEop(outEop), .cellErr(cellErr)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // captured user stream
  logic [7:0] rxData [1024];
  bit         rxSop  [1024];
  bit         rxEop  [1024];
  int         rxN = 0;
  int         errN = 0;

  always @(negedge clk) begin
    if (rstN && outValid && rxN < 1024) begin
      rxData[rxN] = outData;
      rxSop[rxN]  = outSop;
      rxEop[rxN]  = outEop;
      rxN++;
    end
    if (rstN && cellErr) errN++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] octet(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37) + 8'd1;
  endfunction

  // expected user byte k of a cell
  function automatic logic [7:0] expByte(input bit longMode, input logic [7:0] seed,
                                         input int k);
    if (longMode || k < 5) return octet(seed, k);
    if (k == 5) return 8'h00;
    return octet(seed, k - 1);
  endfunction

  // send octets first..last-1 of a cell; gapAt inserts two enable-high cycles
  task automatic sendOctets(input bit longMode, input logic [7:0] seed,
                            input int first, input int last, input int gapAt);
    for (int i = first; i < last; i++) begin
      if (i == gapAt) begin
        txEnN = 1'b1; txSoc = 1'b0; txData = 8'hEE;
        @(negedge clk);
        @(negedge clk);
      end
      cellSizeSel = longMode;
      txEnN  = 1'b0;
      txSoc  = (i == 0);
      txData = octet(seed, i);
      @(negedge clk);
    end
    txEnN = 1'b1; txSoc = 1'b0;
  endtask

  task automatic idle(input int n);
    txEnN = 1'b1; txSoc = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic checkCell(input int base, input bit longMode, input logic [7:0] seed,
                           input string req);
    int bad = -1;
    int eops = 0;
    for (int k = 0; k < 54; k++) begin
      if (bad < 0 && rxData[base + k] !== expByte(longMode, seed, k)) bad = k;
      if (rxEop[base + k]) eops++;
    end
    check(bad < 0, req, "first byte mismatch index", bad, -1);
    check(rxSop[base] == 1'b1, req, "sop on first byte", int'(rxSop[base]), 1);
    check(rxEop[base + 53] == 1'b1 && eops == 1, req, "eop count/placement", eops, 1);
  endtask

  // {longMode, gapAt[6:0] (127 = none), seed[7:0]}
  localparam logic [15:0] VEC [6] = '{
    {1'b1, 7'd127, 8'h10},
    {1'b0, 7'd127, 8'h20},
    {1'b1, 7'd30,  8'h35},
    {1'b0, 7'd3,   8'h4A},
    {1'b0, 7'd6,   8'h5B},
    {1'b1, 7'd53,  8'h6C}
  };

  initial begin
    int base;
    int e0;
    repeat (3) @(negedge clk);
    // R10: quiet during and after reset
    check(outValid == 1'b0 && cellErr == 1'b0, "R10", "outputs in reset",
          int'(outValid) + int'(cellErr), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && cellErr == 1'b0, "R10", "outputs after reset",
          int'(outValid) + int'(cellErr), 0);

    // R1: space flag passthrough, both levels
    wAvail = 1'b1; #1;
    check(txClav == 1'b1, "R1", "txClav high", int'(txClav), 1);
    wAvail = 1'b0; #1;
    check(txClav == 1'b0, "R1", "txClav low", int'(txClav), 0);
    wAvail = 1'b1;
    @(negedge clk);

    // R7: stray octets before any start-of-cell
    base = rxN;
    for (int i = 0; i < 5; i++) begin
      txEnN = 1'b0; txSoc = 1'b0; txData = 8'(i + 90);
      @(negedge clk);
    end
    idle(3);
    check(rxN == base, "R7", "bytes from stray octets", rxN - base, 0);

    // vector table: R2 R3 R4 R5 over modes, gaps and data
    for (int v = 0; v < 6; v++) begin
      bit lm;
      int gap;
      logic [7:0] sd;
      lm  = VEC[v][15];
      gap = int'(VEC[v][14:8]);
      sd  = VEC[v][7:0];
      base = rxN;
      sendOctets(lm, sd, 0, lm ? 54 : 53, gap);
      idle(4);
      check(rxN - base == 54, lm ? "R4" : "R5", "user byte count", rxN - base, 54);
      checkCell(base, lm, sd, (gap != 127) ? "R2" : (lm ? "R4" : "R5"));
    end

    // R6: one-cycle latency on the first octet
    base = rxN;
    cellSizeSel = 1'b1;
    txEnN = 1'b0; txSoc = 1'b1; txData = octet(8'h77, 0);
    @(negedge clk);
    check(outValid && outSop && outData == octet(8'h77, 0), "R6", "first byte next cycle",
          int'(outData), int'(octet(8'h77, 0)));
    sendOctets(1'b1, 8'h77, 1, 54, 127);
    idle(4);
    checkCell(base, 1'b1, 8'h77, "R6");

    // R9: octets after a completed cell are ignored
    base = rxN;
    for (int i = 0; i < 4; i++) begin
      txEnN = 1'b0; txSoc = 1'b0; txData = 8'hA5;
      @(negedge clk);
    end
    idle(3);
    check(rxN == base, "R9", "bytes after cell end", rxN - base, 0);

    // R8: abandon a cell after 10 octets, restart at once
    base = rxN;
    e0 = errN;
    sendOctets(1'b1, 8'h81, 0, 10, 127);
    sendOctets(1'b0, 8'h92, 0, 53, 127);
    idle(5);
    check(errN - e0 == 1, "R8", "error pulses", errN - e0, 1);
    check(rxN - base == 64, "R8", "bytes partial plus new", rxN - base, 64);
    check(rxSop[base] == 1'b1 && rxEop[base + 9] == 1'b0, "R8", "partial framing",
          int'(rxEop[base + 9]), 0);
    checkCell(base + 10, 1'b0, 8'h92, "R8");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule